// File: doc/BRIEF.md
# User-Local Thread Pointer Access Control

This block is one slice of a system-control coprocessor register file. It holds a 64-bit thread-pointer register that user code can read without a trap, and a hardware-register read-enable mask. It also publishes a read-only configuration word; bit 13 of that word says whether the thread-pointer feature exists. The configuration word is fixed by a parameter.

Two ports reach the state. The privileged move port carries a register number, a select, a direction and a width flag. Its results are combinational and appear in the same cycle as the request, and writes take effect at the next rising clock edge. The user read port carries a hardware-register index. In the same cycle it returns either data with a write-back strobe, or a reserved-instruction pulse with zero data.

Instruction decode, exception vectoring and every other coprocessor register are outside this slice. For that reason, hardware indices 0 to 3 pass their permission check here, but their data is zero.

Top module: `tp_access_ctl`

## Requirements
- R1: After reset the thread pointer is zero and the enable mask is zero.
- R2: A privileged write to register 7 select 0 (the enable mask) keeps bits 3:0. It keeps bit 29 only when the feature bit is set. Every other bit reads back as zero.
- R3: A privileged write to register 4 select 2 loads the thread pointer when the feature bit is set. When the feature bit is clear, the write is ignored.
- R4: A privileged read of register 4 select 2 returns the thread pointer when the feature bit is set, and zero otherwise, with no invalid-access flag.
- R5: A word read (mv_dword=0) sign-extends bit 31 of the register into the upper half. A doubleword read (mv_dword=1) of the thread pointer returns all 64 bits. The 32-bit registers always read sign-extended.
- R6: Register 4 with select 1 or select 3 to 7 raises mv_invalid in the request cycle. It returns zero, and a write there changes no state.
- R7: A user read of index 29 returns the thread pointer with hw_wb_valid high when priv_mode is high or enable bit 29 is set. Otherwise it pulses hw_ri_exc with zero data and hw_wb_valid low.
- R8: User reads of indices 0 to 3 are allowed when priv_mode is high or the enable bit of the same number is set, and return zero data. Otherwise they raise hw_ri_exc.
- R9: Any user read index other than 0 to 3 and 29 raises hw_ri_exc, even with priv_mode high.
- R10: Register 16 select 3 reads the configuration parameter (bit 13 = feature present), and writes to it are ignored.
- R11: hw_ri_exc and hw_wb_valid are low whenever hw_req is low, and mv_invalid is low whenever mv_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 1 | Core currently holds coprocessor privilege |
| mv_req | input | 1 | Privileged move request |
| mv_write | input | 1 | 1 = move to register, 0 = move from register |
| mv_dword | input | 1 | 1 = doubleword access, 0 = word access |
| mv_regnum | input | 5 | Coprocessor register number |
| mv_sel | input | 3 | Register select |
| mv_wdata | input | 64 | Write data |
| mv_rdata | output | 64 | Read data, zero for writes and invalid accesses |
| mv_invalid | output | 1 | Invalid-access flag for unimplemented selects |
| hw_req | input | 1 | User hardware-register read request |
| hw_idx | input | 5 | Hardware register index |
| hw_rdata | output | 64 | Read result, zero on exception |
| hw_wb_valid | output | 1 | Result may be written back |
| hw_ri_exc | output | 1 | Reserved-instruction exception pulse |

## Verification
The hardest case to reach is a user-mode read of index 29 that succeeds without privilege. This needs an earlier privileged write that sets enable bit 29, and that write sticks only on the instance with the feature present. The bench drives two instances from the same inputs, one with the feature and one without. It opens with a directed sequence that sets the mask bit, loads a thread pointer with bit 31 set and then reads it both ways. After that comes a random mix of moves and user reads, biased towards registers 4, 7 and 16 and towards index 29, with priv_mode toggled freely.

// File: rtl/tpac_pkg.sv
package tpac_pkg;
  localparam int unsigned FEAT_BIT     = 13;
  localparam int unsigned HWR_TP_IDX   = 29;
  localparam int unsigned HWR_LOW_CNT  = 4;
  localparam logic [4:0]  REG_TP_NUM   = 5'd4;
  localparam logic [2:0]  SEL_TP       = 3'd2;
  localparam logic [2:0]  SEL_CTX      = 3'd0;
  localparam logic [4:0]  REG_HWE_NUM  = 5'd7;
  localparam logic [2:0]  SEL_HWE      = 3'd0;
  localparam logic [4:0]  REG_CFG_NUM  = 5'd16;
  localparam logic [2:0]  SEL_CFG      = 3'd3;
  localparam logic [31:0] HWE_BASE_MASK = 32'h0000_000F;
  localparam logic [31:0] HWE_TP_MASK   = 32'h2000_0000;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TP   = 2'd1,
    TGT_HWE  = 2'd2,
    TGT_CFG  = 2'd3
  } mv_tgt_e;

  typedef struct packed {
    mv_tgt_e tgt;
    logic    bad;
  } mv_dec_t;
endpackage

// File: rtl/tpac_mv_decode.sv
module tpac_mv_decode
  import tpac_pkg::*;
(
  input  logic [4:0] regnum,
  input  logic [2:0] sel,
  output mv_dec_t    dec
);
  always_comb begin
    dec.tgt = TGT_NONE;
    dec.bad = 1'b0;
    if (regnum == REG_TP_NUM) begin
      if (sel == SEL_TP) begin
        dec.tgt = TGT_TP;
      end else if (sel != SEL_CTX) begin
        dec.bad = 1'b1;
      end
    end else if (regnum == REG_HWE_NUM && sel == SEL_HWE) begin
      dec.tgt = TGT_HWE;
    end else if (regnum == REG_CFG_NUM && sel == SEL_CFG) begin
      dec.tgt = TGT_CFG;
    end
  end
endmodule

// File: rtl/tpac_state.sv
module tpac_state
  import tpac_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            feat,
  input  logic            tp_we,
  input  logic [XLEN-1:0] tp_wd,
  input  logic            hwe_we,
  input  logic [31:0]     hwe_wd,
  output logic [XLEN-1:0] tp_q,
  output logic [31:0]     hwe_q
);
  logic [XLEN-1:0] tp_d;
  logic [31:0]     hwe_d;
  logic [31:0]     hwe_mask;

  always_comb begin
    hwe_mask = HWE_BASE_MASK | (feat ? HWE_TP_MASK : 32'h0);
    tp_d     = tp_q;
    hwe_d    = hwe_q;
    if (tp_we)  tp_d  = tp_wd;
    if (hwe_we) hwe_d = hwe_wd & hwe_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q  <= '0;
      hwe_q <= '0;
    end else begin
      if (tp_we)  tp_q  <= tp_d;
      if (hwe_we) hwe_q <= hwe_d;
    end
  end
endmodule

// File: rtl/tpac_hwr_check.sv
module tpac_hwr_check
  import tpac_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            req,
  input  logic            priv,
  input  logic [4:0]      idx,
  input  logic [31:0]     hwe,
  input  logic [XLEN-1:0] tp,
  output logic [XLEN-1:0] rdata,
  output logic            wb_valid,
  output logic            ri_exc
);
  logic known;
  logic allowed;
  logic is_tp;

  always_comb begin
    is_tp   = (idx == 5'(HWR_TP_IDX));
    known   = is_tp || (idx < 5'(HWR_LOW_CNT));
    allowed = known && (priv || hwe[idx]);
    ri_exc   = req && !allowed;
    wb_valid = req && allowed;
    rdata    = (wb_valid && is_tp) ? tp : '0;
  end
endmodule

// File: rtl/tp_access_ctl.sv
module tp_access_ctl
  import tpac_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter logic [31:0] CFG3_VALUE = 32'h8000_2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_mode,
  input  logic            mv_req,
  input  logic            mv_write,
  input  logic            mv_dword,
  input  logic [4:0]      mv_regnum,
  input  logic [2:0]      mv_sel,
  input  logic [XLEN-1:0] mv_wdata,
  output logic [XLEN-1:0] mv_rdata,
  output logic            mv_invalid,
  input  logic            hw_req,
  input  logic [4:0]      hw_idx,
  output logic [XLEN-1:0] hw_rdata,
  output logic            hw_wb_valid,
  output logic            hw_ri_exc
);
  localparam int unsigned EXT_W = XLEN - 32;

  logic            feat_w;
  mv_dec_t         dec;
  logic            tp_we;
  logic            hwe_we;
  logic [XLEN-1:0] tp_q;
  logic [31:0]     hwe_q;
  logic [31:0]     word_src;
  logic            word_reg;

  assign feat_w = CFG3_VALUE[FEAT_BIT];

  tpac_mv_decode dec_i (
    .regnum (mv_regnum),
    .sel    (mv_sel),
    .dec    (dec)
  );

  always_comb begin
    tp_we  = mv_req && mv_write && !dec.bad && (dec.tgt == TGT_TP) && feat_w;
    hwe_we = mv_req && mv_write && !dec.bad && (dec.tgt == TGT_HWE);
  end

  tpac_state #(.XLEN(XLEN)) state_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .feat   (feat_w),
    .tp_we  (tp_we),
    .tp_wd  (mv_wdata),
    .hwe_we (hwe_we),
    .hwe_wd (mv_wdata[31:0]),
    .tp_q   (tp_q),
    .hwe_q  (hwe_q)
  );

  always_comb begin
    mv_invalid = mv_req && dec.bad;
    word_src   = 32'h0;
    word_reg   = 1'b1;
    unique case (dec.tgt)
      TGT_TP: begin
        word_src = feat_w ? tp_q[31:0] : 32'h0;
        word_reg = !mv_dword;
      end
      TGT_HWE: word_src = hwe_q;
      TGT_CFG: word_src = CFG3_VALUE;
      default: word_src = 32'h0;
    endcase
    if (!mv_req || mv_write || dec.bad) begin
      mv_rdata = '0;
    end else if (word_reg) begin
      mv_rdata = {{EXT_W{word_src[31]}}, word_src};
    end else begin
      mv_rdata = feat_w ? tp_q : '0;
    end
  end

  tpac_hwr_check #(.XLEN(XLEN)) hwr_i (
    .req      (hw_req),
    .priv     (priv_mode),
    .idx      (hw_idx),
    .hwe      (hwe_q),
    .tp       (tp_q),
    .rdata    (hw_rdata),
    .wb_valid (hw_wb_valid),
    .ri_exc   (hw_ri_exc)
  );
endmodule

// File: rtl/tp_access_ctl_chk.sv
module tp_access_ctl_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            feat,
  input logic            mv_req,
  input logic            mv_write,
  input logic [4:0]      mv_regnum,
  input logic [2:0]      mv_sel,
  input logic            mv_invalid,
  input logic            hw_req,
  input logic [4:0]      hw_idx,
  input logic [XLEN-1:0] hw_rdata,
  input logic            hw_wb_valid,
  input logic            hw_ri_exc,
  input logic [XLEN-1:0] tp_q,
  input logic [31:0]     hwe_q
);
  // R11
  idle_hw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_req |-> (!hw_ri_exc && !hw_wb_valid));
  // R11
  idle_mv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_req |-> !mv_invalid);
  // R7
  exc_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ri_exc |-> (hw_rdata == '0 && !hw_wb_valid));
  // R9
  unknown_idx_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && hw_idx > 5'd3 && hw_idx != 5'd29) |-> hw_ri_exc);
  // R6
  sel1_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && mv_regnum == 5'd4 && mv_sel == 3'd1) |-> mv_invalid);
  // R3
  tp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv_req && mv_write && mv_regnum == 5'd4 && mv_sel == 3'd2 && feat)
      |=> $stable(tp_q));
  // R2
  hwe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hwe_q & ~(32'h0000_000F | (feat ? 32'h2000_0000 : 32'h0))) == 32'h0);
endmodule

bind tp_access_ctl tp_access_ctl_chk #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .feat        (feat_w),
  .mv_req      (mv_req),
  .mv_write    (mv_write),
  .mv_regnum   (mv_regnum),
  .mv_sel      (mv_sel),
  .mv_invalid  (mv_invalid),
  .hw_req      (hw_req),
  .hw_idx      (hw_idx),
  .hw_rdata    (hw_rdata),
  .hw_wb_valid (hw_wb_valid),
  .hw_ri_exc   (hw_ri_exc),
  .tp_q        (tp_q),
  .hwe_q       (hwe_q)
);

// File: tb/tp_access_ctl_tb_top.sv
module tp_access_ctl_tb_top;
  localparam logic [31:0] CFG_F = 32'h8000_2000;
  localparam logic [31:0] CFG_N = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_mode = 1'b0;
  logic        mv_req = 1'b0, mv_write = 1'b0, mv_dword = 1'b0;
  logic [4:0]  mv_regnum = '0;
  logic [2:0]  mv_sel = '0;
  logic [63:0] mv_wdata = '0;
  logic        hw_req = 1'b0;
  logic [4:0]  hw_idx = '0;

  logic [63:0] f_mv_rdata, n_mv_rdata, f_hw_rdata, n_hw_rdata;
  logic        f_inv, n_inv, f_wb, n_wb, f_exc, n_exc;

  int checks = 0;
  int fails  = 0;

  logic [63:0] tp_f = '0, tp_n = '0;
  logic [31:0] he_f = '0, he_n = '0;

  always #5 clk = ~clk;

  tp_access_ctl #(.XLEN(64), .CFG3_VALUE(CFG_F)) dut_i (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .mv_req(mv_req), .mv_write(mv_write), .mv_dword(mv_dword),
    .mv_regnum(mv_regnum), .mv_sel(mv_sel), .mv_wdata(mv_wdata),
    .mv_rdata(f_mv_rdata), .mv_invalid(f_inv),
    .hw_req(hw_req), .hw_idx(hw_idx), .hw_rdata(f_hw_rdata),
    .hw_wb_valid(f_wb), .hw_ri_exc(f_exc));

  tp_access_ctl #(.XLEN(64), .CFG3_VALUE(CFG_N)) dut_nf_i (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .mv_req(mv_req), .mv_write(mv_write), .mv_dword(mv_dword),
    .mv_regnum(mv_regnum), .mv_sel(mv_sel), .mv_wdata(mv_wdata),
    .mv_rdata(n_mv_rdata), .mv_invalid(n_inv),
    .hw_req(hw_req), .hw_idx(hw_idx), .hw_rdata(n_hw_rdata),
    .hw_wb_valid(n_wb), .hw_ri_exc(n_exc));

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic bad_sel(input logic [4:0] r, input logic [2:0] s);
    return (r == 5'd4) && (s != 3'd0) && (s != 3'd2);
  endfunction

  function automatic logic [63:0] exp_mv(input logic feat, input logic [31:0] cfg,
      input logic [63:0] tp, input logic [31:0] he, input logic [4:0] r,
      input logic [2:0] s, input logic wr, input logic dw);
    if (wr || bad_sel(r, s)) return 64'h0;
    if (r == 5'd4 && s == 3'd2) begin
      if (!feat) return 64'h0;
      return dw ? tp : sx(tp[31:0]);
    end
    if (r == 5'd7 && s == 3'd0) return sx(he);
    if (r == 5'd16 && s == 3'd3) return sx(cfg);
    return 64'h0;
  endfunction

  function automatic logic hw_ok(input logic pv, input logic [31:0] he,
      input logic [4:0] i);
    if (i == 5'd29) return pv || he[29];
    if (i < 5'd4) return pv || he[i];
    return 1'b0;
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, check combinational outputs, then commit writes.
  task automatic step(input logic pv, input logic mq, input logic wr, input logic dw,
      input logic [4:0] r, input logic [2:0] s, input logic [63:0] wd,
      input logic hq, input logic [4:0] ix, input string tag);
    logic okf, okn;
    @(negedge clk);
    priv_mode = pv; mv_req = mq; mv_write = wr; mv_dword = dw;
    mv_regnum = r; mv_sel = s; mv_wdata = wd; hw_req = hq; hw_idx = ix;
    #2;
    if (mq) begin
      chk64({tag, " R4/R5/R10 mv_rdata feat"}, f_mv_rdata,
            exp_mv(1'b1, CFG_F, tp_f, he_f, r, s, wr, dw));
      chk64({tag, " R4/R5/R10 mv_rdata nofeat"}, n_mv_rdata,
            exp_mv(1'b0, CFG_N, tp_n, he_n, r, s, wr, dw));
      chk1({tag, " R6 mv_invalid"}, f_inv, bad_sel(r, s));
      chk1({tag, " R6 mv_invalid nofeat"}, n_inv, bad_sel(r, s));
    end else begin
      chk1({tag, " R11 mv_invalid idle"}, f_inv | n_inv, 1'b0);
    end
    if (hq) begin
      okf = hw_ok(pv, he_f, ix);
      okn = hw_ok(pv, he_n, ix);
      chk1({tag, " R7/R8/R9 exc feat"}, f_exc, !okf);
      chk1({tag, " R7/R8/R9 wb feat"}, f_wb, okf);
      chk64({tag, " R7/R8 hw_rdata feat"}, f_hw_rdata,
            (okf && ix == 5'd29) ? tp_f : 64'h0);
      chk1({tag, " R7/R8/R9 exc nofeat"}, n_exc, !okn);
      chk64({tag, " R7/R8 hw_rdata nofeat"}, n_hw_rdata,
            (okn && ix == 5'd29) ? tp_n : 64'h0);
    end else begin
      chk1({tag, " R11 hw idle"}, f_exc | f_wb | n_exc | n_wb, 1'b0);
    end
    @(posedge clk);
    if (mq && wr && !bad_sel(r, s)) begin
      if (r == 5'd4 && s == 3'd2) tp_f = wd;
      if (r == 5'd7 && s == 3'd0) begin
        he_f = wd[31:0] & 32'h2000_000F;
        he_n = wd[31:0] & 32'h0000_000F;
      end
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values read back through the move port
    step(1, 1, 0, 1, 5'd4, 3'd2, 64'h0, 0, 5'd0, "R1 tp reset");
    step(1, 1, 0, 0, 5'd7, 3'd0, 64'h0, 0, 5'd0, "R1 mask reset");
    // R10: config word read, write ignored
    step(1, 1, 0, 0, 5'd16, 3'd3, 64'h0, 0, 5'd0, "R10 cfg read");
    step(1, 1, 1, 0, 5'd16, 3'd3, 64'hFFFF, 0, 5'd0, "R10 cfg write");
    step(1, 1, 0, 1, 5'd16, 3'd3, 64'h0, 0, 5'd0, "R10 cfg reread");
    // R7: no privilege, mask clear -> exception
    step(0, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'd29, "R7 denied");
    // R2: mask write with all bits
    step(1, 1, 1, 0, 5'd7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5'd0, "R2 mask write");
    step(1, 1, 0, 0, 5'd7, 3'd0, 64'h0, 0, 5'd0, "R2 mask read");
    // R3: thread pointer write with bit 31 set
    step(1, 1, 1, 1, 5'd4, 3'd2, 64'h1234_5678_9ABC_DEF0, 0, 5'd0, "R3 tp write");
    // R5: word vs doubleword read
    step(1, 1, 0, 0, 5'd4, 3'd2, 64'h0, 0, 5'd0, "R5 word read");
    step(1, 1, 0, 1, 5'd4, 3'd2, 64'h0, 0, 5'd0, "R5 dword read");
    // R7: user read enabled by mask bit 29 (feature only)
    step(0, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'd29, "R7 enabled");
    // R6: select 1 invalid, write there ignored
    step(1, 1, 1, 1, 5'd4, 3'd1, 64'hDEAD, 0, 5'd0, "R6 sel1 write");
    step(1, 1, 0, 1, 5'd4, 3'd5, 64'h0, 0, 5'd0, "R6 sel5 read");
    step(1, 1, 0, 1, 5'd4, 3'd2, 64'h0, 0, 5'd0, "R6 tp unchanged");
    // R9: unknown index in privileged mode
    step(1, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'd5, "R9 priv idx5");
    step(1, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'd31, "R9 priv idx31");
    // R8: low indices with partial mask
    step(1, 1, 1, 0, 5'd7, 3'd0, 64'h5, 0, 5'd0, "R8 mask 0101");
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'(i), "R8 low idx");
    step(0, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'd29, "R7 bit29 cleared");
    step(1, 0, 0, 0, 5'd0, 3'd0, 64'h0, 1, 5'd29, "R7 priv");
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] r, ix;
      logic [2:0] s;
      logic [63:0] wd;
      int unsigned pick;
      pick = $urandom % 4;
      r = (pick == 0) ? 5'd4 : (pick == 1) ? 5'd7 : (pick == 2) ? 5'd16 : 5'($urandom);
      s = (pick == 0) ? 3'($urandom) : (pick == 1) ? 3'd0 : (pick == 2) ? 3'd3 : 3'($urandom % 4);
      pick = $urandom % 3;
      ix = (pick == 0) ? 5'd29 : (pick == 1) ? 5'($urandom % 4) : 5'($urandom);
      wd = {$urandom, $urandom};
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), r, s, wd,
           1'($urandom), ix, "rand");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule